// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer

This block moves single-cycle event strobes from one clock domain into another clock domain whose frequency and phase have no fixed relation to the first. A strobe does not cross the boundary directly. Each accepted strobe inverts a level register in the source domain. That level passes through a parameterised chain of capture flip-flops clocked by the destination clock. A final flop holds the previous value of the chain output, and comparing the two turns every observed level change back into one destination-cycle strobe.

The capture flops either have no reset and rely on their declared initial value, or are cleared only by the destination reset. One parameter selects between the two. Another parameter sets the level that both the source register and the capture flops return to on reset. The source register is cleared only by the source reset. Strobes must be spaced far enough apart for the destination side to see every level change.

Top module: `pulseSyncTop`

## Requirements
- R1: While both resets are held, `dstPulse` is low. After both resets are released with no strobe sent, no `dstPulse` appears.
- R2: With strobes at least STAGES+2 destination periods apart, the number of `dstPulse` pulses equals the number of accepted `srcPulse` strobes.
- R3: Every `dstPulse` is high for exactly one destination clock cycle.
- R4: A strobe captured at a source rising edge raises `dstPulse` in the destination cycle that follows the STAGES-th destination rising edge after that source edge. Before that cycle `dstPulse` is low.
- R5: A `srcPulse` that is high while `srcRst` is high is ignored and produces no `dstPulse`.
- R6: `srcRst` on its own returns the source level to RESET_LEVEL. If the level held the opposite value, the destination reports exactly one `dstPulse`.
- R7: The latency in R4 follows the STAGES parameter: 2 destination edges by default, and 3 when STAGES is 3.
- R8: When RESETTABLE is 1, `dstRst` forces the capture flops to RESET_LEVEL. If the source level differs, one `dstPulse` follows the release of `dstRst`. When RESETTABLE is 0, `dstRst` has no effect on the capture flops or on `dstPulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source domain synchronous reset, active high |
| srcPulse | input | 1 | Single-cycle event strobe in the source domain |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination domain synchronous reset, active high |
| dstPulse | output | 1 | One-cycle event strobe in the destination domain |

## Verification
The properties assume the following about the inputs. `srcPulse` is high for one source cycle at a time. Consecutive strobes are spaced by more than STAGES+2 destination periods, so the destination never misses a level change. Both resets are held together at start-up, so the two domains begin at the same level. The stimulus uses source-cycle gaps of at least eight periods of 20 ns, which is 160 ns and longer than the 135 ns needed by the three-stage variant at 27 ns. It asserts both resets together before any strobe. It applies `dstRst` alone only in the directed case that tests that reset.

// File: rtl/pulseSyncPkg.sv
package pulseSyncPkg;

  // source-domain strobes from control to datapath
  typedef struct packed {
    logic flip;      // invert the crossing level
    logic clearSrc;  // return the crossing level to its reset value
  } srcStrobes_t;

  // destination-domain strobes from control to datapath
  typedef struct packed {
    logic clearCapture;  // force capture chain and edge flop to reset value
  } dstStrobes_t;

  // smallest usable capture chain
  localparam int unsigned MinStages = 2;

endpackage

// File: rtl/pulseSyncCtrl.sv
module pulseSyncCtrl
  import pulseSyncPkg::*;
#(
  parameter bit RESETTABLE = 1'b0
) (
  input  logic        srcRst,
  input  logic        srcPulse,
  input  logic        dstRst,
  output srcStrobes_t srcStb,
  output dstStrobes_t dstStb
);

  // a strobe arriving during source reset is dropped
  always_comb begin
    srcStb.clearSrc = srcRst;
    srcStb.flip     = srcPulse & ~srcRst;
  end

  // capture flops see only the destination reset, and only when enabled
  always_comb begin
    dstStb.clearCapture = RESETTABLE & dstRst;
  end

endmodule

// File: rtl/pulseSyncPath.sv
module pulseSyncPath
  import pulseSyncPkg::*;
#(
  parameter int unsigned STAGES      = 2,
  parameter bit          RESET_LEVEL = 1'b0
) (
  input  logic        srcClk,
  input  logic        dstClk,
  input  srcStrobes_t srcStb,
  input  dstStrobes_t dstStb,
  output logic        dstPulse,
  output logic        toggleLevel,
  output logic        syncLast
);

  localparam int unsigned Depth = (STAGES < MinStages) ? MinStages : STAGES;
  localparam logic [Depth-1:0] ChainInit = {Depth{RESET_LEVEL}};

  // source domain: non-return-to-zero level, one inversion per strobe
  logic levelQ;

  always_ff @(posedge srcClk) begin
    if (srcStb.clearSrc) begin
      levelQ <= RESET_LEVEL;
    end else if (srcStb.flip) begin
      levelQ <= ~levelQ;
    end
  end

  assign toggleLevel = levelQ;

  // destination domain: capture chain and edge flop, power-up value set
  logic [Depth-1:0] chainQ = ChainInit;
  logic             edgeQ  = RESET_LEVEL;

  always_ff @(posedge dstClk) begin
    if (dstStb.clearCapture) begin
      chainQ <= ChainInit;
      edgeQ  <= RESET_LEVEL;
    end else begin
      chainQ <= {chainQ[Depth-2:0], levelQ};
      edgeQ  <= chainQ[Depth-1];
    end
  end

  assign syncLast = chainQ[Depth-1];
  assign dstPulse = chainQ[Depth-1] ^ edgeQ;

endmodule

// File: rtl/pulseSyncTop.sv
module pulseSyncTop
  import pulseSyncPkg::*;
#(
  parameter int unsigned STAGES      = 2,
  parameter bit          RESETTABLE  = 1'b0,
  parameter bit          RESET_LEVEL = 1'b0
) (
  input  logic srcClk,
  input  logic srcRst,
  input  logic srcPulse,
  input  logic dstClk,
  input  logic dstRst,
  output logic dstPulse
);

  srcStrobes_t srcStb;
  dstStrobes_t dstStb;
  logic        toggleLevel;
  logic        syncLast;

  pulseSyncCtrl #(
    .RESETTABLE(RESETTABLE)
  ) ctrl_i (
    .srcRst  (srcRst),
    .srcPulse(srcPulse),
    .dstRst  (dstRst),
    .srcStb  (srcStb),
    .dstStb  (dstStb)
  );

  pulseSyncPath #(
    .STAGES     (STAGES),
    .RESET_LEVEL(RESET_LEVEL)
  ) path_i (
    .srcClk     (srcClk),
    .dstClk     (dstClk),
    .srcStb     (srcStb),
    .dstStb     (dstStb),
    .dstPulse   (dstPulse),
    .toggleLevel(toggleLevel),
    .syncLast   (syncLast)
  );

endmodule

// File: rtl/pulseSyncChecker.sv
module pulseSyncChecker #(
  parameter bit RESETTABLE  = 1'b0,
  parameter bit RESET_LEVEL = 1'b0
) (
  input logic srcClk,
  input logic srcRst,
  input logic srcPulse,
  input logic dstClk,
  input logic dstRst,
  input logic dstPulse,
  input logic level,
  input logic syncOut
);

  // R2: an accepted strobe inverts the crossing level
  assert_src_flip_R2: assert property (@(posedge srcClk) disable iff (srcRst)
    srcPulse |=> (level != $past(level)));

  // R2: without a strobe or reset the level holds
  assert_src_hold_R2: assert property (@(posedge srcClk) disable iff (srcRst)
    (!srcPulse && !srcRst) |=> ($stable(level) || srcRst));

  // R3: output pulse lasts one destination cycle
  assert_one_cycle_R3: assert property (@(posedge dstClk) disable iff (dstRst)
    dstPulse |=> !dstPulse);

  // R4: a pulse only follows a change at the end of the capture chain
  assert_pulse_origin_R4: assert property (@(posedge dstClk) disable iff (dstRst)
    dstPulse |-> (syncOut != $past(syncOut)));

  generate
    if (RESETTABLE) begin : gRstChk
      // R8: after destination reset the chain output sits at the reset level
      assert_capture_cleared_R8: assert property (@(posedge dstClk) disable iff (dstRst)
        $fell(dstRst) |-> (syncOut == RESET_LEVEL));
    end
  endgenerate

endmodule

bind pulseSyncTop pulseSyncChecker #(
  .RESETTABLE (RESETTABLE),
  .RESET_LEVEL(RESET_LEVEL)
) chk_i (
  .srcClk  (srcClk),
  .srcRst  (srcRst),
  .srcPulse(srcPulse),
  .dstClk  (dstClk),
  .dstRst  (dstRst),
  .dstPulse(dstPulse),
  .level   (toggleLevel),
  .syncOut (syncLast)
);

// File: tb/pulseSyncTop_tb.sv
`timescale 1ns/1ps
module pulseSyncTop_tb_top;

  logic srcClk = 1'b0;
  logic dstClk = 1'b0;
  logic srcRst = 1'b1;
  logic dstRst = 1'b1;
  logic srcPulse = 1'b0;
  logic dstPulseA;
  logic dstPulseB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int cntA = 0, cntB = 0, wideA = 0, wideB = 0;
  logic prevA = 1'b0, prevB = 1'b0;
  int sentTotal = 0;

  always #10 srcClk = ~srcClk;    // 50 MHz source
  always #13.5 dstClk = ~dstClk;  // unrelated destination

  pulseSyncTop dut_i (
    .srcClk(srcClk), .srcRst(srcRst), .srcPulse(srcPulse),
    .dstClk(dstClk), .dstRst(dstRst), .dstPulse(dstPulseA)
  );

  pulseSyncTop #(.STAGES(3), .RESETTABLE(1'b1), .RESET_LEVEL(1'b1)) dutAlt_i (
    .srcClk(srcClk), .srcRst(srcRst), .srcPulse(srcPulse),
    .dstClk(dstClk), .dstRst(dstRst), .dstPulse(dstPulseB)
  );

  always @(negedge dstClk) begin
    if (dstPulseA) cntA++;
    if (dstPulseB) cntB++;
    if (dstPulseA && prevA) wideA++;
    if (dstPulseB && prevB) wideB++;
    prevA = dstPulseA;
    prevB = dstPulseB;
  end

  function automatic int expLatency(input int stages);
    return stages;
  endfunction

  function automatic int expPulses(input int accepted);
    return accepted;
  endfunction

  task automatic checkEq(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge srcClk);
  endtask

  task automatic sendPulse();
    @(negedge srcClk) srcPulse = 1'b1;
    @(negedge srcClk) srcPulse = 1'b0;
    if (!srcRst) sentTotal++;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int baseA, baseB, firstA, firstB, n, gap, seedDummy;
    seedDummy = $urandom(32'h5EED1);

    // R1: quiet during and after reset
    idle(10);
    @(negedge dstClk);
    checkEq("R1 dut_i pulse in reset", int'(dstPulseA), 0);
    checkEq("R1 dutAlt_i pulse in reset", int'(dstPulseB), 0);
    @(negedge srcClk) srcRst = 1'b0;
    @(negedge dstClk) dstRst = 1'b0;
    idle(20);
    checkEq("R1 dut_i pulses after release", cntA, 0);
    checkEq("R1/R8 dutAlt_i pulses after release", cntB, 0);

    // R4 and R7: latency in destination edges
    firstA = 0; firstB = 0;
    @(negedge srcClk) srcPulse = 1'b1;
    fork
      begin
        @(posedge srcClk);
        @(negedge srcClk) srcPulse = 1'b0;
      end
      begin
        @(posedge srcClk);
        for (int k = 1; k <= 6; k++) begin
          @(posedge dstClk);
          @(negedge dstClk);
          if (dstPulseA && firstA == 0) firstA = k;
          if (dstPulseB && firstB == 0) firstB = k;
        end
      end
    join
    sentTotal++;
    checkEq("R4 dut_i latency", firstA, expLatency(2));
    checkEq("R7 dutAlt_i latency", firstB, expLatency(3));
    checkEq("R2 single pulse dut_i", cntA, expPulses(1));
    checkEq("R2 single pulse dutAlt_i", cntB, expPulses(1));

    // R2 and R3: random bursts plus a minimum-gap burst
    for (int r = 0; r < 5; r++) begin
      baseA = cntA; baseB = cntB;
      n = 5 + int'($urandom % 20);
      for (int i = 0; i < n; i++) begin
        gap = (r == 4) ? 8 : 8 + int'($urandom % 8);
        sendPulse();
        idle(gap - 2);
      end
      idle(20);
      checkEq("R2 burst count dut_i", cntA - baseA, expPulses(n));
      checkEq("R2 burst count dutAlt_i", cntB - baseB, expPulses(n));
    end
    checkEq("R3 wide pulses dut_i", wideA, 0);
    checkEq("R3 wide pulses dutAlt_i", wideB, 0);

    // R6: source reset alone from the opposite level
    if (sentTotal % 2 == 0) begin
      sendPulse();
      idle(20);
    end
    baseA = cntA; baseB = cntB;
    @(negedge srcClk) srcRst = 1'b1;
    idle(2);
    @(negedge srcClk) srcRst = 1'b0;
    sentTotal = 0;
    idle(20);
    checkEq("R6 srcRst pulse dut_i", cntA - baseA, 1);
    checkEq("R6 srcRst pulse dutAlt_i", cntB - baseB, 1);

    // R5: strobes during source reset are ignored
    baseA = cntA; baseB = cntB;
    @(negedge srcClk) srcRst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sendPulse();
      idle(6);
    end
    @(negedge srcClk) srcRst = 1'b0;
    idle(20);
    checkEq("R5 ignored in reset dut_i", cntA - baseA, 0);
    checkEq("R5 ignored in reset dutAlt_i", cntB - baseB, 0);
    sendPulse();
    idle(20);
    checkEq("R5 recovery dut_i", cntA - baseA, 1);
    checkEq("R5 recovery dutAlt_i", cntB - baseB, 1);

    // R8: destination reset alone, source level differs from RESET_LEVEL of dutAlt_i
    baseA = cntA; baseB = cntB;
    @(negedge dstClk) dstRst = 1'b1;
    repeat (3) @(negedge dstClk);
    checkEq("R8 dutAlt_i quiet in dstRst", int'(dstPulseB), 0);
    dstRst = 1'b0;
    idle(20);
    checkEq("R8 non-resettable dut_i unaffected", cntA - baseA, 0);
    checkEq("R8 resettable dutAlt_i repulse", cntB - baseB, 1);
    checkEq("R3 wide pulses final", wideA + wideB, 0);

    finish();
  end

endmodule